// File: doc/BRIEF.md
# PWM Pin Protection and Override Stage

This block sits on the path from one PWM generator's high/low output pair to the two pins. It watches two protection inputs, a fault signal and a current-limit signal, each of which can be declared active-high or active-low. When one of them is active, it replaces the PWM levels on both pins with a two-bit pattern set up for that input. A fault can be held until software clears it, or it can be held only for the current PWM cycle. A current limit is always held until the next cycle start. Software can also drive either pin to a level of its own choosing. That override can take effect on the next clock, or it can wait for the next PWM cycle boundary.

Switching edges tend to cause false trips on the sense inputs. To prevent this, a blanking window can be opened on any chosen mix of four events: the high signal rising, the high signal falling, the low signal rising and the low signal falling. While the window is open, each protection input whose blanking is enabled is ignored. Two sticky flags record that a fault or a current limit was seen. Each flag is held clear while its enable input is low.

Every two-bit pattern in this block (fault, current-limit and override data) uses the same bit order: bit 1 drives the high pin and bit 0 drives the low pin.

Top module: `pwm_guard`

## Requirements
- R1: While `rst` is high, both pins and both flags are 0 after the next clock edge.
- R2: With no protection and no override active, `pin_hi`/`pin_lo` equal `pwm_hi`/`pwm_lo` as sampled at the previous clock edge.
- R3: A protection input counts as active when the raw level XOR its invert bit is 1. An invert bit of 1 makes the input active-low.
- R4: With `fault_mode` = 00 (latched), an active fault forces the pins to `fault_pat` from the next edge on. The force stays after the input goes inactive. It is released only at a `cycle_start` edge where the input is inactive and `fault_clear` has been pulsed at or after the time the fault was taken.
- R5: With `fault_mode` = 01 (per cycle), an active fault forces `fault_pat` until the first `cycle_start` edge at which the fault input is inactive.
- R6: With `fault_mode` = 10 or 11, the fault input has no effect on the pins or on `fault_flag`.
- R7: With `limit_en` = 1, an active limit input forces `limit_pat` until the first `cycle_start` edge at which the limit input is inactive. With `limit_en` = 0, the limit input has no effect.
- R8: Each pin takes its level from the highest-priority active source. The order is fault, then current limit, then software override, then the PWM signal.
- R9: When `ovr_hi_en` is set, `pin_hi` takes `ovr_pat[1]`; when `ovr_lo_en` is set, `pin_lo` takes `ovr_pat[0]`. With `ovr_sync` = 0, a change to the override inputs reaches the pins at the next edge. With `ovr_sync` = 1, the previous override setting stays in force until an edge where `cycle_start` is high.
- R10: `blank_edges` selects the events that open the blanking window: bit 3 is `pwm_hi` rising, bit 2 is `pwm_hi` falling, bit 1 is `pwm_lo` rising and bit 0 is `pwm_lo` falling. The window covers the edge where the event is seen, plus the following edges until `blank_len` cycles with `blank_tick` high have passed.
- R11: `blank_fault_en` and `blank_limit_en` act independently. An input whose blanking is disabled is acted on even while the window is open.
- R12: `fault_flag`/`limit_flag` are set at the edge that samples an enabled, active input, and then stay set. Each flag is 0 at every edge where its enable (`fault_irq_en`/`limit_irq_en`) is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_hi | input | 1 | Raw PWM high-side signal |
| pwm_lo | input | 1 | Raw PWM low-side signal |
| cycle_start | input | 1 | One-cycle strobe at each PWM period start |
| fault_raw | input | 1 | Fault sense input |
| fault_inv | input | 1 | 1 = fault input active-low |
| fault_mode | input | 2 | 00 latched, 01 per cycle, 10/11 off |
| fault_pat | input | 2 | Pin pattern while faulted |
| fault_clear | input | 1 | Release request for a latched fault |
| limit_raw | input | 1 | Current-limit sense input |
| limit_inv | input | 1 | 1 = limit input active-low |
| limit_en | input | 1 | Enables current-limit response |
| limit_pat | input | 2 | Pin pattern while limiting |
| ovr_hi_en | input | 1 | Software override of high pin |
| ovr_lo_en | input | 1 | Software override of low pin |
| ovr_pat | input | 2 | Software override pattern |
| ovr_sync | input | 1 | 1 = override changes wait for cycle start |
| blank_edges | input | 4 | Blanking start event select |
| blank_fault_en | input | 1 | Apply blanking to fault input |
| blank_limit_en | input | 1 | Apply blanking to limit input |
| blank_len | input | 7 | Blanking length in ticks |
| blank_tick | input | 1 | Blanking count enable |
| fault_irq_en | input | 1 | Fault flag enable; low clears flag |
| limit_irq_en | input | 1 | Limit flag enable; low clears flag |
| pin_hi | output | 1 | Final high pin level |
| pin_lo | output | 1 | Final low pin level |
| fault_flag | output | 1 | Sticky fault seen |
| limit_flag | output | 1 | Sticky current limit seen |

## Verification
Each internal hold state drives the pin register directly, so a wrong hold or release shows on both pins at the very next edge. Examples are a latched fault that releases without a clear, or a per-cycle limit that does not release at the cycle start. A blanking counter that loads or drains wrongly moves the first unmasked edge by one or more cycles. The bench checks every edge across the window to catch this. A wrongly staged override change appears one edge too early or at a point that is not a cycle boundary.

// File: rtl/pwm_guard_pkg.sv
package pwm_guard_pkg;

    typedef enum logic [1:0] {
        FM_LATCH = 2'b00,
        FM_CYCLE = 2'b01,
        FM_RSVD  = 2'b10,
        FM_OFF   = 2'b11
    } fault_mode_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } pin_pair_t;

    typedef struct packed {
        logic      hi_en;
        logic      lo_en;
        pin_pair_t pat;
    } ovr_cfg_t;

    // bit positions of the blanking start select
    localparam int EDGE_HR = 3;
    localparam int EDGE_HF = 2;
    localparam int EDGE_LR = 1;
    localparam int EDGE_LF = 0;
    localparam int N_EDGE  = 4;
    localparam int N_PROT  = 2;
    localparam int IDX_FLT = 0;
    localparam int IDX_LIM = 1;

    function automatic pin_pair_t to_pair(input logic [1:0] v);
        pin_pair_t p;
        p.hi = v[1];
        p.lo = v[0];
        return p;
    endfunction

endpackage

// File: rtl/pwm_guard_blank.sv
module pwm_guard_blank
    import pwm_guard_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  pin_pair_t        pwm,
    input  logic [N_EDGE-1:0] edge_sel,
    input  logic             tick,
    input  logic [CNT_W-1:0] len,
    output logic             window
);

    pin_pair_t          prev_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [N_EDGE-1:0]  seen;
    logic               start;

    always_comb begin
        seen          = '0;
        seen[EDGE_HR] =  pwm.hi & ~prev_q.hi;
        seen[EDGE_HF] = ~pwm.hi &  prev_q.hi;
        seen[EDGE_LR] =  pwm.lo & ~prev_q.lo;
        seen[EDGE_LF] = ~pwm.lo &  prev_q.lo;
        start         = |(seen & edge_sel);
        window        = start | (cnt_q != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            cnt_q  <= '0;
        end else begin
            prev_q <= pwm;
            if (start)
                cnt_q <= len;
            else if (tick && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_blank_load_R10: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt_q == $past(len)));

    assert_blank_drain_R10: assert property (@(posedge clk) disable iff (rst)
        (!start && tick && cnt_q == {{(CNT_W-1){1'b0}}, 1'b1}) |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_guard_prot.sv
module pwm_guard_prot
    import pwm_guard_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fault_act,
    input  logic        limit_act,
    input  fault_mode_e fault_mode,
    input  logic        limit_en,
    input  logic        cycle_start,
    input  logic        fault_clear,
    input  logic        fault_irq_en,
    input  logic        limit_irq_en,
    output logic        fault_force,
    output logic        limit_force,
    output logic        fault_flag,
    output logic        limit_flag
);

    logic fault_q, pend_q, limit_q, fflag_q, lflag_q;
    logic f_hit, l_hit, f_next, pend_next, l_next;

    always_comb begin
        f_hit = ((fault_mode == FM_LATCH) || (fault_mode == FM_CYCLE)) && fault_act;
        l_hit = limit_en && limit_act;
        unique case (fault_mode)
            FM_LATCH: begin
                if (f_hit)
                    f_next = 1'b1;
                else if (fault_q && cycle_start && (pend_q || fault_clear))
                    f_next = 1'b0;
                else
                    f_next = fault_q;
            end
            FM_CYCLE: f_next = f_hit ? 1'b1 : (cycle_start ? 1'b0 : fault_q);
            default:  f_next = 1'b0;
        endcase
        pend_next = f_next && (pend_q || (fault_clear && fault_q));
        l_next    = l_hit || (limit_en && limit_q && !cycle_start);
    end

    assign fault_force = f_next;
    assign limit_force = l_next;
    assign fault_flag  = fflag_q;
    assign limit_flag  = lflag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= 1'b0;
            pend_q  <= 1'b0;
            limit_q <= 1'b0;
            fflag_q <= 1'b0;
            lflag_q <= 1'b0;
        end else begin
            fault_q <= f_next;
            pend_q  <= pend_next;
            limit_q <= l_next;
            fflag_q <= fault_irq_en && (fflag_q || f_hit);
            lflag_q <= limit_irq_en && (lflag_q || l_hit);
        end
    end

    assert_latch_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (fault_q && fault_mode == FM_LATCH && !cycle_start) |=> fault_q);

    assert_cycle_release_R5: assert property (@(posedge clk) disable iff (rst)
        (fault_mode == FM_CYCLE && cycle_start && !fault_act) |=> !fault_q);

    assert_fault_off_R6: assert property (@(posedge clk) disable iff (rst)
        fault_mode[1] |=> !fault_q);

    assert_limit_take_R7: assert property (@(posedge clk) disable iff (rst)
        (limit_en && limit_act) |=> limit_q);

    assert_flag_cleared_R12: assert property (@(posedge clk) disable iff (rst)
        !fault_irq_en |=> !fflag_q);

endmodule

// File: rtl/pwm_guard_ovr.sv
module pwm_guard_ovr
    import pwm_guard_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ovr_cfg_t cfg_in,
    input  logic     sync,
    input  logic     cycle_start,
    output ovr_cfg_t cfg_eff
);

    ovr_cfg_t cfg_q;

    always_comb begin
        if (!sync || cycle_start)
            cfg_eff = cfg_in;
        else
            cfg_eff = cfg_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else
            cfg_q <= cfg_eff;
    end

    assert_sync_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (sync && !cycle_start) |-> (cfg_eff == cfg_q));

endmodule

// File: rtl/pwm_guard.sv
module pwm_guard
    import pwm_guard_pkg::*;
#(
    parameter int BLANK_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwm_hi,
    input  logic               pwm_lo,
    input  logic               cycle_start,
    input  logic               fault_raw,
    input  logic               fault_inv,
    input  logic [1:0]         fault_mode,
    input  logic [1:0]         fault_pat,
    input  logic               fault_clear,
    input  logic               limit_raw,
    input  logic               limit_inv,
    input  logic               limit_en,
    input  logic [1:0]         limit_pat,
    input  logic               ovr_hi_en,
    input  logic               ovr_lo_en,
    input  logic [1:0]         ovr_pat,
    input  logic               ovr_sync,
    input  logic [3:0]         blank_edges,
    input  logic               blank_fault_en,
    input  logic               blank_limit_en,
    input  logic [BLANK_W-1:0] blank_len,
    input  logic               blank_tick,
    input  logic               fault_irq_en,
    input  logic               limit_irq_en,
    output logic               pin_hi,
    output logic               pin_lo,
    output logic               fault_flag,
    output logic               limit_flag
);

    pin_pair_t          pwm_in, pins_d, pins_q;
    ovr_cfg_t           ovr_in, ovr_eff;
    logic               window;
    logic [N_PROT-1:0]  raw_v, inv_v, blk_v, act_v;
    logic               fault_force, limit_force;

    assign pwm_in = '{hi: pwm_hi, lo: pwm_lo};
    assign ovr_in = '{hi_en: ovr_hi_en, lo_en: ovr_lo_en, pat: to_pair(ovr_pat)};

    assign raw_v[IDX_FLT] = fault_raw;
    assign raw_v[IDX_LIM] = limit_raw;
    assign inv_v[IDX_FLT] = fault_inv;
    assign inv_v[IDX_LIM] = limit_inv;
    assign blk_v[IDX_FLT] = blank_fault_en;
    assign blk_v[IDX_LIM] = blank_limit_en;

    for (genvar gi = 0; gi < N_PROT; gi++) begin : g_qual
        assign act_v[gi] = (raw_v[gi] ^ inv_v[gi]) & ~(blk_v[gi] & window);
    end

    pwm_guard_blank #(.CNT_W(BLANK_W)) u_blank (
        .clk      (clk),
        .rst      (rst),
        .pwm      (pwm_in),
        .edge_sel (blank_edges),
        .tick     (blank_tick),
        .len      (blank_len),
        .window   (window)
    );

    pwm_guard_prot u_prot (
        .clk          (clk),
        .rst          (rst),
        .fault_act    (act_v[IDX_FLT]),
        .limit_act    (act_v[IDX_LIM]),
        .fault_mode   (fault_mode_e'(fault_mode)),
        .limit_en     (limit_en),
        .cycle_start  (cycle_start),
        .fault_clear  (fault_clear),
        .fault_irq_en (fault_irq_en),
        .limit_irq_en (limit_irq_en),
        .fault_force  (fault_force),
        .limit_force  (limit_force),
        .fault_flag   (fault_flag),
        .limit_flag   (limit_flag)
    );

    pwm_guard_ovr u_ovr (
        .clk         (clk),
        .rst         (rst),
        .cfg_in      (ovr_in),
        .sync        (ovr_sync),
        .cycle_start (cycle_start),
        .cfg_eff     (ovr_eff)
    );

    always_comb begin
        pins_d = pwm_in;
        if (ovr_eff.hi_en) pins_d.hi = ovr_eff.pat.hi;
        if (ovr_eff.lo_en) pins_d.lo = ovr_eff.pat.lo;
        if (limit_force)   pins_d = to_pair(limit_pat);
        if (fault_force)   pins_d = to_pair(fault_pat);
    end

    always_ff @(posedge clk) begin
        if (rst)
            pins_q <= '0;
        else
            pins_q <= pins_d;
    end

    assign pin_hi = pins_q.hi;
    assign pin_lo = pins_q.lo;

    assert_fault_first_R8: assert property (@(posedge clk) disable iff (rst)
        fault_force |=> ({pin_hi, pin_lo} == $past(fault_pat)));

    assert_limit_over_ovr_R8: assert property (@(posedge clk) disable iff (rst)
        (limit_force && !fault_force) |=> ({pin_hi, pin_lo} == $past(limit_pat)));

    assert_ovr_now_R9: assert property (@(posedge clk) disable iff (rst)
        (!ovr_sync && ovr_hi_en && !fault_force && !limit_force) |=> (pin_hi == $past(ovr_pat[1])));

endmodule

// File: tb/pwm_guard_test.sv
`timescale 1ns/1ps
module pwm_guard_test;

    logic clk = 1'b0;
    logic rst;
    logic pwm_hi, pwm_lo, cycle_start;
    logic fault_raw, fault_inv, fault_clear;
    logic [1:0] fault_mode, fault_pat;
    logic limit_raw, limit_inv, limit_en;
    logic [1:0] limit_pat;
    logic ovr_hi_en, ovr_lo_en, ovr_sync;
    logic [1:0] ovr_pat;
    logic [3:0] blank_edges;
    logic blank_fault_en, blank_limit_en, blank_tick;
    logic [6:0] blank_len;
    logic fault_irq_en, limit_irq_en;
    logic pin_hi, pin_lo, fault_flag, limit_flag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwm_guard uut (.*);

    // fields: pwm_hi, pwm_lo, fault_raw, fault_inv, expected {hi,lo}
    localparam logic [5:0] VEC [8] = '{
        6'b10_00_10, 6'b01_00_01, 6'b11_10_01, 6'b10_11_10,
        6'b00_01_01, 6'b11_00_11, 6'b00_00_00, 6'b10_10_01
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic neutral();
        pwm_hi = 0; pwm_lo = 0; cycle_start = 0;
        fault_raw = 0; fault_inv = 0; fault_clear = 0;
        fault_mode = 2'b11; fault_pat = 2'b00;
        limit_raw = 0; limit_inv = 0; limit_en = 0; limit_pat = 2'b00;
        ovr_hi_en = 0; ovr_lo_en = 0; ovr_sync = 0; ovr_pat = 2'b00;
        blank_edges = 4'b0000; blank_fault_en = 0; blank_limit_en = 0;
        blank_tick = 0; blank_len = 7'd0;
        fault_irq_en = 0; limit_irq_en = 0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        neutral();
        pwm_hi = 1; pwm_lo = 1;
        rst = 1;
        tick(); tick();
        // R1 reset state
        chk("R1 pins", {pin_hi, pin_lo}, 2'b00);
        chk("R1 flags", {fault_flag, limit_flag}, 2'b00);
        rst = 0;
        neutral();
        tick();

        // R2 pass-through and R3 polarity, per-cycle fault, cycle start every clock
        fault_mode = 2'b01; fault_pat = 2'b01; cycle_start = 1;
        for (int i = 0; i < 8; i++) begin
            {pwm_hi, pwm_lo, fault_raw, fault_inv} = VEC[i][5:2];
            tick();
            chk("R2 R3 vector", {pin_hi, pin_lo}, VEC[i][1:0]);
        end

        // R4 latched fault
        neutral(); tick();
        fault_mode = 2'b00; fault_pat = 2'b11; pwm_hi = 1;
        fault_raw = 1; tick();
        chk("R4 take", {pin_hi, pin_lo}, 2'b11);
        fault_raw = 0; tick();
        chk("R4 hold inactive", {pin_hi, pin_lo}, 2'b11);
        cycle_start = 1; tick();
        chk("R4 no clear", {pin_hi, pin_lo}, 2'b11);
        cycle_start = 0; fault_clear = 1; tick();
        chk("R4 clear mid cycle", {pin_hi, pin_lo}, 2'b11);
        fault_clear = 0; cycle_start = 1; tick();
        chk("R4 release", {pin_hi, pin_lo}, 2'b10);
        cycle_start = 0; fault_raw = 1; tick();
        fault_clear = 1; tick();
        fault_clear = 0; cycle_start = 1; tick();
        chk("R4 still active", {pin_hi, pin_lo}, 2'b11);
        fault_raw = 0; tick();
        chk("R4 release later", {pin_hi, pin_lo}, 2'b10);

        // R5 per-cycle fault
        neutral(); tick();
        fault_mode = 2'b01; fault_pat = 2'b00; pwm_lo = 1;
        fault_raw = 1; tick();
        chk("R5 take", {pin_hi, pin_lo}, 2'b00);
        fault_raw = 0; tick();
        chk("R5 hold", {pin_hi, pin_lo}, 2'b00);
        cycle_start = 1; tick();
        chk("R5 release", {pin_hi, pin_lo}, 2'b01);

        // R6 fault modes off
        neutral(); tick();
        pwm_hi = 1; fault_pat = 2'b01; fault_irq_en = 1; fault_raw = 1;
        fault_mode = 2'b10; tick();
        chk("R6 mode 10", {pin_hi, pin_lo}, 2'b10);
        fault_mode = 2'b11; tick();
        chk("R6 mode 11", {pin_hi, pin_lo, fault_flag}, 3'b100);

        // R7 current limit
        neutral(); tick();
        pwm_hi = 1; limit_en = 1; limit_pat = 2'b01;
        limit_raw = 1; tick();
        chk("R7 take", {pin_hi, pin_lo}, 2'b01);
        limit_raw = 0; tick();
        chk("R7 hold", {pin_hi, pin_lo}, 2'b01);
        cycle_start = 1; tick();
        chk("R7 release", {pin_hi, pin_lo}, 2'b10);
        limit_en = 0; limit_raw = 1; tick();
        chk("R7 disabled", {pin_hi, pin_lo}, 2'b10);

        // R8 priority
        neutral(); tick();
        fault_mode = 2'b01; fault_pat = 2'b01; fault_raw = 1;
        limit_en = 1; limit_pat = 2'b10; limit_raw = 1;
        ovr_hi_en = 1; ovr_lo_en = 1; ovr_pat = 2'b11;
        tick();
        chk("R8 fault wins", {pin_hi, pin_lo}, 2'b01);
        fault_raw = 0; cycle_start = 1; tick();
        chk("R8 limit next", {pin_hi, pin_lo}, 2'b10);
        limit_raw = 0; tick();
        chk("R8 override next", {pin_hi, pin_lo}, 2'b11);
        ovr_hi_en = 0; ovr_lo_en = 0; tick();
        chk("R8 pwm last", {pin_hi, pin_lo}, 2'b00);

        // R9 override immediate and synchronized
        neutral(); tick();
        pwm_hi = 1; pwm_lo = 1; ovr_hi_en = 1; ovr_pat = 2'b00;
        tick();
        chk("R9 immediate hi", {pin_hi, pin_lo}, 2'b01);
        ovr_sync = 1; ovr_lo_en = 1; tick();
        chk("R9 sync waits", {pin_hi, pin_lo}, 2'b01);
        cycle_start = 1; tick();
        chk("R9 sync applies", {pin_hi, pin_lo}, 2'b00);

        // R10 blanking window on high rising edge
        neutral(); tick();
        fault_mode = 2'b01; fault_pat = 2'b11; blank_fault_en = 1;
        blank_edges = 4'b1000; blank_len = 7'd3; blank_tick = 1; cycle_start = 1;
        tick();
        pwm_hi = 1; fault_raw = 1;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R10 masked", {pin_hi, pin_lo}, 2'b10);
        end
        tick();
        chk("R10 window over", {pin_hi, pin_lo}, 2'b11);
        pwm_hi = 0; tick();
        chk("R10 unselected edge", {pin_hi, pin_lo}, 2'b11);

        // R11 limit not blanked while fault blanking is on
        fault_raw = 0; tick();
        limit_en = 1; limit_pat = 2'b01; limit_raw = 1; pwm_hi = 1;
        tick();
        chk("R11 limit unblanked", {pin_hi, pin_lo}, 2'b01);

        // R12 flags
        neutral(); tick();
        fault_mode = 2'b01; fault_irq_en = 1; limit_irq_en = 1;
        fault_raw = 1; tick();
        chk("R12 fault flag set", {fault_flag, limit_flag}, 2'b10);
        fault_raw = 0; cycle_start = 1; tick();
        chk("R12 fault flag sticky", {fault_flag, limit_flag}, 2'b10);
        fault_irq_en = 0; limit_en = 1; limit_raw = 1; tick();
        chk("R12 clear and limit set", {fault_flag, limit_flag}, 2'b01);
        limit_irq_en = 0; tick();
        chk("R12 limit clear", {fault_flag, limit_flag}, 2'b00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule